// File: doc/BRIEF.md
# Phase-Shifted Variable-Frequency PWM Pair

This block makes a pulse-width-modulated waveform whose frequency and phase offset can be changed while it runs. Two up-counters share one programmable period. A free-running master counter wraps every `period+1` clocks and emits a one-clock trigger pulse when its count reaches a programmable phase value. Each trigger restarts a one-shot slave counter, which runs through exactly one period, drives the PWM output from a duty compare and then stops until the next trigger.

Period, phase and duty are written together into shadow registers with a single write strobe. The master copies the whole set into its working registers only at its wrap point, or at once while disabled. A change therefore never cuts a cycle short or stretches it, and the waveform has no jitter across updates. A polarity input chooses between low-then-high and high-then-low output inside each slave period. The idle level of the output equals the polarity bit.

Top module: `pwm_pair`

## Requirements
- R1: After reset, with `en` low and `pol` low, `pwm_out` is 0 and `trig_out` is 0.
- R2: While enabled with phase below period, `trig_out` is high for exactly one clock and repeats every `period+1` clocks.
- R3: Take the cycle where `en` is first seen high as master count 0. The first `trig_out` pulse appears `phase+1` clocks later, and each later pulse comes `phase+1` clocks after a master wrap.
- R4: Each trigger restarts the slave at count 0. With `pol`=0 the output is low while the slave count is below `duty` and high from `duty` through `period`. The output is registered one clock after the slave count, so the output period is `period+1` clocks.
- R5: With `pol`=1 the output waveform is inverted, and the idle level is 1.
- R6: If phase is equal to or greater than period, `trig_out` never pulses and `pwm_out` stays at the idle level `pol`.
- R7: A strobe on `cfg_wr` captures period, phase and duty as one set. While enabled, the set takes effect only at the next master wrap. The master cycle in progress keeps its old length.
- R8: When `en` is low, both counters are cleared and the shadow set loads straight into the working registers. Within 2 clocks of `en` falling, `pwm_out` equals `pol` and `trig_out` is 0.
- R9: A duty value greater than period keeps `pwm_out` at the idle level for the whole slave period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; when low, the counters are cleared |
| cfg_wr | input | 1 | Strobe that captures the period, phase and duty inputs |
| period_in | input | CNT_W | Shared period; the counters run 0..period |
| phase_in | input | CNT_W | Master count at which the trigger fires |
| duty_in | input | CNT_W | Slave count at which the output changes level |
| pol | input | 1 | 0: low then high; 1: high then low; also the idle level |
| pwm_out | output | 1 | Registered PWM output |
| trig_out | output | 1 | One-clock master trigger pulse, for debug |

## Verification
A wrong master count or a late reload of the working set changes the spacing of `trig_out` pulses within one period. The bench pins every pulse to an exact clock. A slave counter that fails to restart, overruns or stops early shifts or stretches the `pwm_out` edges in the first triggered period. Each run compares every single clock against a computed waveform, so the fault shows at once. A phase value at the period boundary and an update in the middle of a cycle are each checked down to the exact clock.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic {SL_IDLE, SL_RUN} slave_st_e;
endpackage

// File: rtl/pwm_pair_shadow.sv
module pwm_pair_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_wr,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] phase_in,
  input  logic [W-1:0] duty_in,
  output logic [W-1:0] sh_per,
  output logic [W-1:0] sh_ph,
  output logic [W-1:0] sh_duty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_per  <= '0;
      sh_ph   <= '0;
      sh_duty <= '0;
    end else if (cfg_wr) begin
      sh_per  <= period_in;
      sh_ph   <= phase_in;
      sh_duty <= duty_in;
    end
  end
endmodule

// File: rtl/pwm_pair_master.sv
module pwm_pair_master #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] sh_per,
  input  logic [W-1:0] sh_ph,
  input  logic [W-1:0] sh_duty,
  output logic [W-1:0] m_cnt,
  output logic [W-1:0] per_act,
  output logic [W-1:0] ph_act,
  output logic [W-1:0] duty_act,
  output logic         trig
);
  localparam logic [W-1:0] ONE = W'(1);

  logic wrap;
  logic hit;

  assign wrap = (m_cnt == per_act);
  // compare output rises only when phase lies inside the count range
  assign hit  = (m_cnt == ph_act) && (ph_act < per_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_cnt    <= '0;
      per_act  <= '0;
      ph_act   <= '0;
      duty_act <= '0;
      trig     <= 1'b0;
    end else if (!en) begin
      m_cnt    <= '0;
      per_act  <= sh_per;
      ph_act   <= sh_ph;
      duty_act <= sh_duty;
      trig     <= 1'b0;
    end else begin
      trig <= hit;
      if (wrap) begin
        m_cnt    <= '0;
        per_act  <= sh_per;
        ph_act   <= sh_ph;
        duty_act <= sh_duty;
      end else begin
        m_cnt <= m_cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/pwm_pair_slave.sv
module pwm_pair_slave
  import pwm_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         trig,
  input  logic         pol,
  input  logic [W-1:0] per_act,
  input  logic [W-1:0] duty_act,
  output logic [W-1:0] s_cnt,
  output logic [W-1:0] s_per,
  output logic         s_running,
  output logic         pwm_q
);
  localparam logic [W-1:0] ONE = W'(1);

  slave_st_e    st;
  logic [W-1:0] s_duty;
  logic         lvl;

  assign s_running = (st == SL_RUN);
  assign lvl       = s_running && (s_cnt >= s_duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SL_IDLE;
      s_cnt  <= '0;
      s_per  <= '0;
      s_duty <= '0;
    end else if (!en) begin
      st    <= SL_IDLE;
      s_cnt <= '0;
    end else if (trig) begin
      st     <= SL_RUN;
      s_cnt  <= '0;
      s_per  <= per_act;
      s_duty <= duty_act;
    end else if (st == SL_RUN) begin
      if (s_cnt == s_per) st <= SL_IDLE;
      else                s_cnt <= s_cnt + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pol ^ lvl;
  end
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] phase_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic             pol,
  output logic             pwm_out,
  output logic             trig_out
);
  logic [CNT_W-1:0] sh_per, sh_ph, sh_duty;
  logic [CNT_W-1:0] m_cnt, per_act, ph_act, duty_act;
  logic [CNT_W-1:0] s_cnt, s_per;
  logic             s_running;
  logic             trig;

  pwm_pair_shadow #(.W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
    .period_in(period_in), .phase_in(phase_in), .duty_in(duty_in),
    .sh_per(sh_per), .sh_ph(sh_ph), .sh_duty(sh_duty)
  );

  pwm_pair_master #(.W(CNT_W)) u_master (
    .clk(clk), .rst(rst), .en(en),
    .sh_per(sh_per), .sh_ph(sh_ph), .sh_duty(sh_duty),
    .m_cnt(m_cnt), .per_act(per_act), .ph_act(ph_act), .duty_act(duty_act),
    .trig(trig)
  );

  pwm_pair_slave #(.W(CNT_W)) u_slave (
    .clk(clk), .rst(rst), .en(en), .trig(trig), .pol(pol),
    .per_act(per_act), .duty_act(duty_act),
    .s_cnt(s_cnt), .s_per(s_per), .s_running(s_running), .pwm_q(pwm_out)
  );

  assign trig_out = trig;
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         pol,
  input logic         trig_out,
  input logic         pwm_out,
  input logic [W-1:0] m_cnt,
  input logic [W-1:0] per_act,
  input logic [W-1:0] ph_act,
  input logic [W-1:0] s_cnt,
  input logic [W-1:0] s_per,
  input logic         s_running
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  trig_single_chk: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);

  // R4
  slave_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_out && en) |=> (s_running && s_cnt == '0));

  // R4
  slave_bound_chk: assert property (@(posedge clk) disable iff (rst)
    s_running |-> (s_cnt <= s_per));

  // R7
  per_load_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !$stable(per_act)) |-> (m_cnt == '0));

  // R6
  no_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && trig_out) |-> ($past(ph_act) < $past(per_act)));

  // R8
  idle_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && !$past(en) && !$past(en, 2) && $stable(pol)) |-> (pwm_out == pol));
endmodule

bind pwm_pair pwm_pair_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pol(pol),
  .trig_out(trig_out), .pwm_out(pwm_out),
  .m_cnt(m_cnt), .per_act(per_act), .ph_act(ph_act),
  .s_cnt(s_cnt), .s_per(s_per), .s_running(s_running)
);

// File: tb/test_pwm_pair.sv
`timescale 1ns/1ps
module test_pwm_pair;
  localparam int W = 8;
  localparam int NV = 7;
  // {period, phase, duty, pol}
  localparam logic [31:0] VEC [NV] = '{
    {8'd9, 8'd2, 8'd5, 8'd0},
    {8'd7, 8'd0, 8'd4, 8'd1},
    {8'd4, 8'd3, 8'd0, 8'd0},
    {8'd6, 8'd6, 8'd2, 8'd0},
    {8'd5, 8'd8, 8'd1, 8'd1},
    {8'd3, 8'd1, 8'd7, 8'd0},
    {8'd1, 8'd0, 8'd1, 8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cfg_wr = 1'b0;
  logic [W-1:0] period_in = '0, phase_in = '0, duty_in = '0;
  logic pol = 1'b0;
  logic pwm_out, trig_out;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_pair #(.CNT_W(W)) i_pwm_pair (
    .clk(clk), .rst(rst), .en(en), .cfg_wr(cfg_wr),
    .period_in(period_in), .phase_in(phase_in), .duty_in(duty_in),
    .pol(pol), .pwm_out(pwm_out), .trig_out(trig_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int p, input int ph, input int d);
    @(negedge clk);
    period_in = W'(p); phase_in = W'(ph); duty_in = W'(d);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_vec(input int vi);
    int p, ph, d, pl, n, bad_pwm, bad_trg, first_pwm, first_trg, ep, et;
    string tag;
    p  = int'(VEC[vi][31:24]);
    ph = int'(VEC[vi][23:16]);
    d  = int'(VEC[vi][15:8]);
    pl = int'(VEC[vi][7:0]);
    pol = pl[0];
    cfg_write(p, ph, d);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    n = 4 * (p + 1) + ph + 6;
    bad_pwm = 0; bad_trg = 0; first_pwm = -1; first_trg = -1;
    for (int m = 0; m < n; m++) begin
      if (ph >= p) begin
        ep = pl; et = 0;
      end else begin
        et = (m >= ph + 1 && ((m - ph - 1) % (p + 1)) == 0) ? 1 : 0;
        if (m < ph + 3) ep = pl;
        else ep = pl ^ ((((m - ph - 3) % (p + 1)) >= d) ? 1 : 0);
      end
      if (int'(pwm_out) != ep) begin
        bad_pwm++;
        if (first_pwm < 0) first_pwm = m;
      end
      if (int'(trig_out) != et) begin
        bad_trg++;
        if (first_trg < 0) first_trg = m;
      end
      @(negedge clk);
    end
    // R4 R5 R6 R9 waveform per clock
    tag = (ph >= p) ? "R6" : (d > p) ? "R9" : (pl != 0) ? "R5" : "R4";
    if (bad_pwm != 0)
      $display("FAIL %s vec%0d pwm mismatch from clock %0d", tag, vi, first_pwm);
    chk(tag, bad_pwm, 0);
    // R2 R3 trigger spacing and offset
    if (bad_trg != 0)
      $display("FAIL R2/R3 vec%0d trig mismatch from clock %0d", vi, first_trg);
    chk("R3", bad_trg, 0);
    // R8 disable
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 pwm idle", int'(pwm_out), pl);
    chk("R8 trig", int'(trig_out), 0);
  endtask

  initial begin
    int tr [8];
    int nt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 pwm", int'(pwm_out), 0);
    chk("R1 trig", int'(trig_out), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R7: change period mid-cycle; trig at 3, 13 (old length), then 19, 25
    pol = 1'b0;
    cfg_write(9, 2, 5);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    nt = 0;
    for (int m = 0; m < 30; m++) begin
      if (trig_out && nt < 8) begin
        tr[nt] = m;
        nt++;
      end
      if (m == 5) begin
        period_in = 8'd5; phase_in = 8'd2; duty_in = 8'd3;
        cfg_wr = 1'b1;
      end else begin
        cfg_wr = 1'b0;
      end
      @(negedge clk);
    end
    chk("R7 count", nt, 4);
    chk("R7 first", tr[0], 3);
    chk("R7 old cycle kept", tr[1], 13);
    chk("R7 new period", tr[2], 19);
    chk("R7 new period repeat", tr[3], 25);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 final idle", int'(pwm_out), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule